// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands of `N` bits each and returns a product of `2N` bits. It does not form the product in one combinational step. It works one multiplier bit at a time, using a single `N`-bit adder.

The block has a datapath and a separate four-state controller. The datapath holds these registers:

- a multiplicand register;
- a multiplier register, whose bits are consumed from the low end;
- a partial-product register;
- a carry flip-flop;
- a bit counter with a zero flag.

For each multiplier bit the controller spends two cycles. In the first cycle it decrements the counter and, if the multiplier's low bit is set, adds the multiplicand into the partial product. In the second cycle it shifts the chain {carry, partial product, multiplier} right by one place.

To use the block, wait for `ready`, present both operands and pulse `start` for one cycle. After a fixed number of cycles `ready` returns, and the product stays on `product` until the next start. A parameter chooses how the controller state is stored: a 2-bit binary code (idle=00, clear=01, add=10, shift=11) or a 4-bit one-hot code (0001, 0010, 0100, 1000). Both encodings behave identically at the ports.

Top module: `mulseq_top`

## Requirements
- R1: A synchronous active-high `rst` forces the block idle. While `rst` is high and in the cycle after it falls, `ready` is 1 and `product` is 0.
- R2: While idle with `start` low, `ready` stays 1 and `product` holds its value, even if the operand inputs change.
- R3: When `start` is 1 at a clock edge while `ready` is 1, both operands are captured at that edge and `ready` is 0 in the following cycle.
- R4: `ready` returns to 1 exactly 2N+1 clock edges after the edge that captured the operands, and stays 0 in between.
- R5: When `ready` returns, `product` equals the unsigned product of the captured operands. For N=5, 23 times 19 gives 437.
- R6: While busy, `start` and the operand inputs are ignored. A run whose inputs change mid-operation still produces the product of the operands captured at its start.
- R7: Full-scale operands (all ones) give (2^N-1)^2 exactly. The carry out of each addition is kept and enters the top of the partial product on the following shift.
- R8: A zero in either operand gives a product of 0.
- R9: The `ONE_HOT` parameter changes only the state storage. Both encodings give the same `ready` and `product` sequence for the same inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication (sampled only while idle) |
| mcand | input | N | Multiplicand operand |
| mplier | input | N | Multiplier operand |
| ready | output | 1 | High while idle; the product is valid |
| product | output | 2N | Product {partial product, multiplier register} |

## Verification
The bench runs the stated example (23 × 19) and a sparse multiplier (a single high bit), which tells apart correct per-bit alignment from an off-by-one shift. All-ones operands show whether the carry flip-flop feeds back into the partial product. Zero in either operand shows that the add is skipped for clear multiplier bits. A run whose inputs are disturbed mid-operation, and a long idle stretch with changing operands, show that the operands are captured only at the start. Binary and one-hot controllers run side by side on every pattern, so any mismatch between the two encodings is visible.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_CLEAR = 2'b01,
        ST_ADD   = 2'b10,
        ST_SHIFT = 2'b11
    } mul_state_e;

    // Control strobes from the controller to the datapath
    typedef struct packed {
        logic idle;
        logic clear;
        logic add_ph;
        logic shift_ph;
        logic load_sum;
    } mul_ctrl_t;

    function automatic mul_state_e mul_next(input mul_state_e cur,
                                            input logic start,
                                            input logic zero);
        case (cur)
            ST_IDLE:  return start ? ST_CLEAR : ST_IDLE;
            ST_CLEAR: return ST_ADD;
            ST_ADD:   return ST_SHIFT;
            default:  return zero ? ST_IDLE : ST_ADD;
        endcase
    endfunction

    function automatic logic [3:0] mul_onehot(input mul_state_e s);
        return 4'b0001 << s;
    endfunction

endpackage

// File: rtl/mulseq_ctrl.sv
module mulseq_ctrl
    import mulseq_pkg::*;
#(
    parameter bit ONE_HOT = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      zero,
    input  logic      q0,
    output mul_ctrl_t ctrl
);

    generate
        if (ONE_HOT) begin : g_onehot
            logic [3:0] oh_q;
            mul_state_e cur;

            always_comb begin
                unique case (1'b1)
                    oh_q[1]: cur = ST_CLEAR;
                    oh_q[2]: cur = ST_ADD;
                    oh_q[3]: cur = ST_SHIFT;
                    default: cur = ST_IDLE;
                endcase
            end

            always_ff @(posedge clk) begin
                if (rst) oh_q <= 4'b0001;
                else     oh_q <= mul_onehot(mul_next(cur, start, zero));
            end

            always_comb begin
                ctrl.idle     = oh_q[0];
                ctrl.clear    = oh_q[1];
                ctrl.add_ph   = oh_q[2];
                ctrl.shift_ph = oh_q[3];
                ctrl.load_sum = oh_q[2] & q0;
            end
        end else begin : g_binary
            mul_state_e st_q;

            always_ff @(posedge clk) begin
                if (rst) st_q <= ST_IDLE;
                else     st_q <= mul_next(st_q, start, zero);
            end

            always_comb begin
                ctrl.idle     = (st_q == ST_IDLE);
                ctrl.clear    = (st_q == ST_CLEAR);
                ctrl.add_ph   = (st_q == ST_ADD);
                ctrl.shift_ph = (st_q == ST_SHIFT);
                ctrl.load_sum = (st_q == ST_ADD) & q0;
            end
        end
    endgenerate

endmodule

// File: rtl/mulseq_dpath.sv
module mulseq_dpath
    import mulseq_pkg::*;
#(
    parameter int N  = 8,
    parameter int PW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    input  mul_ctrl_t      ctrl,
    output logic           q0,
    output logic           zero,
    output logic [2*N-1:0] product
);

    logic [N-1:0]  b_q, q_q, a_q;
    logic          c_q;
    logic [PW-1:0] p_q;
    logic [N:0]    sum;

    assign sum     = {1'b0, a_q} + {1'b0, b_q};
    assign q0      = q_q[0];
    assign zero    = (p_q == '0);
    assign product = {a_q, q_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            b_q <= '0;
            q_q <= '0;
            a_q <= '0;
            c_q <= 1'b0;
            p_q <= '0;
        end else begin
            if (ctrl.idle && start) begin
                b_q <= mcand;
                q_q <= mplier;
            end
            if (ctrl.clear) begin
                a_q <= '0;
                c_q <= 1'b0;
                p_q <= PW'(N);
            end
            if (ctrl.add_ph) begin
                p_q <= p_q - 1'b1;
            end
            if (ctrl.load_sum) begin
                a_q <= sum[N-1:0];
                c_q <= sum[N];
            end
            if (ctrl.shift_ph) begin
                {c_q, a_q, q_q} <= {1'b0, c_q, a_q, q_q[N-1:1]};
            end
        end
    end

endmodule

// File: rtl/mulseq_top.sv
module mulseq_top
    import mulseq_pkg::*;
#(
    parameter int N       = 8,
    parameter bit ONE_HOT = 1'b0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    output logic           ready,
    output logic [2*N-1:0] product
);

    localparam int PW = $clog2(N + 1);

    mul_ctrl_t ctrl;
    logic      q0;
    logic      zero;

    mulseq_ctrl #(.ONE_HOT(ONE_HOT)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .zero  (zero),
        .q0    (q0),
        .ctrl  (ctrl)
    );

    mulseq_dpath #(.N(N), .PW(PW)) u_dpath (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mcand   (mcand),
        .mplier  (mplier),
        .ctrl    (ctrl),
        .q0      (q0),
        .zero    (zero),
        .product (product)
    );

    assign ready = ctrl.idle;

endmodule

// File: rtl/mulseq_chk.sv
module mulseq_chk #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [N-1:0]   mcand,
    input logic [N-1:0]   mplier,
    input logic           ready,
    input logic [2*N-1:0] product
);

    localparam int LAT = 2 * N + 1;

    int             busy_cnt;
    logic [2*N-1:0] want;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= 0;
            want     <= '0;
        end else if (ready && start) begin
            busy_cnt <= 1;
            want     <= (2*N)'(mcand) * (2*N)'(mplier);
        end else if (!ready) begin
            busy_cnt <= busy_cnt + 1;
        end
    end

    // R1
    a_r1_reset_idle: assert property (@(posedge clk) rst |=> ready && product == '0);

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        ready && !start |=> ready && $stable(product));

    a_r3_start_leaves_idle: assert property (@(posedge clk) disable iff (rst)
        ready && start |=> !ready);

    a_r4_latency: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> busy_cnt == LAT + 1);

    a_r4_no_overrun: assert property (@(posedge clk) disable iff (rst)
        !ready |-> busy_cnt <= LAT);

    a_r5_product: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> product == want);

endmodule

bind mulseq_top mulseq_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .mcand   (mcand),
    .mplier  (mplier),
    .ready   (ready),
    .product (product)
);

// File: tb/test_mulseq_top.sv
module test_mulseq_top;

    localparam int N   = 5;
    localparam int LAT = 2 * N + 1;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [N-1:0]   mcand = '0;
    logic [N-1:0]   mplier = '0;
    logic           ready, ready_oh;
    logic [2*N-1:0] product, product_oh;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mulseq_top #(.N(N), .ONE_HOT(1'b0)) i_mulseq_top (
        .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
        .ready(ready), .product(product));

    mulseq_top #(.N(N), .ONE_HOT(1'b1)) i_mulseq_top_oh (
        .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
        .ready(ready_oh), .product(product_oh));

    task automatic check(input string req, input logic [2*N-1:0] act,
                         input logic [2*N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R9: both encodings must agree on every observed cycle
    task automatic check_pair(input string req);
        check({req, " R9 ready"}, (2*N)'(ready_oh), (2*N)'(ready));
        check({req, " R9 product"}, product_oh, product);
    endtask

    // Drive at a falling edge; sample at falling edges after each rising edge
    task automatic run_mul(input logic [N-1:0] a, input logic [N-1:0] b,
                           input bit disturb, input string req);
        logic [2*N-1:0] exp;
        exp = (2*N)'(a) * (2*N)'(b);
        mcand = a; mplier = b; start = 1'b1;
        @(negedge clk);
        check({req, " R3 ready low"}, (2*N)'(ready), '0);
        start = 1'b0;
        for (int k = 1; k < LAT; k++) begin
            if (disturb) begin
                start  = k[0];
                mcand  = ~a;
                mplier = ~b;
            end
            @(negedge clk);
        end
        check({req, " R4 still busy"}, (2*N)'(ready), '0);
        start = 1'b0;
        @(negedge clk);
        check({req, " R4 ready back"}, (2*N)'(ready), 1);
        check(req, product, exp);
        check_pair(req);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 ready in reset", (2*N)'(ready), 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready", (2*N)'(ready), 1);
        check("R1 product", product, '0);
        check_pair("R1");
    endtask

    task automatic t_idle_hold();
        logic [2*N-1:0] held;
        held = product;
        for (int k = 0; k < 6; k++) begin
            mcand = N'(k * 7); mplier = N'(k * 3 + 1);
            @(negedge clk);
            check("R2 ready", (2*N)'(ready), 1);
            check("R2 product", product, held);
        end
    endtask

    initial begin
        t_reset();
        run_mul(5'd23, 5'd19, 1'b0, "R5 example");
        run_mul(5'd6, 5'd16, 1'b0, "R5 sparse");
        run_mul(5'd31, 5'd31, 1'b0, "R7 full scale");
        run_mul(5'd0, 5'd27, 1'b0, "R8 zero mcand");
        run_mul(5'd29, 5'd0, 1'b0, "R8 zero mplier");
        t_idle_hold();
        run_mul(5'd13, 5'd11, 1'b1, "R6 disturbed");
        run_mul(5'd1, 5'd31, 1'b0, "R5 unit");
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        #1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule